// File: doc/BRIEF.md
# Clock Stop and Power-Down Gate

This block sits between a clock generator and its output pins. It receives a vector of already-generated clock lanes. Each lane is a single-bit waveform that changes on the reference clock `clk`. The block passes each lane through a per-lane gate. Three active-low control pins are asynchronous to `clk` and are brought into its domain by synchronizers:

- a power-down request;
- a stop request for the processor lane;
- a stop request for the gated PCI lanes.

Per-lane enable bits from the configuration registers also hold individual lanes low. Some lanes are free-running and ignore some of these controls.

A gate never cuts a lane in the middle of a high phase. It closes, and it reopens, only on a cycle in which the lane input has just gone from high to low. As a result, a stopped lane always ends on a full high pulse and restarts with a full low phase followed by a full high pulse. The block has no data stream, so there is no valid/ready handshake. All pins are plain level controls.

The PLL shutdown is represented only by the `pwrdn_status` output. It reports that a qualified power-down is in force and every lane is held low.

Lane index map with the default parameters (6 gated PCI lanes, 6 SDRAM lanes), 21 lanes in total:

| Index | Lane |
|---|---|
| 0 | processor |
| 1 | free-running processor |
| 2 | free-running PCI |
| 3..8 | gated PCI 1..6 |
| 9..14 | SDRAM 0..5 |
| 15 | memory-hub clock |
| 16 | 66 MHz hub/graphics |
| 17 | reference |
| 18 | USB |
| 19 | dot |
| 20 | video hub |

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `lane_out` and `pwrdn_status` is 0. After reset every gate starts closed and opens at the first falling edge of its lane input.
- R2: A lane whose gate is open drives `lane_out[i]` equal to `lane_in[i]` delayed by exactly one `clk` cycle.
- R3: A gate closes only in a cycle where the lane input has just fallen (input high on the previous rising edge of `clk`, low on this one). `lane_out` therefore never falls while the delayed input is still high.
- R4: A closed gate reopens only on such a falling-edge cycle. The first high pulse after a restart is therefore a full high phase, preceded by a full low phase.
- R5: With `cpu_stop_n` low, only lane 0 is held low. Lane 1 and all other lanes keep running.
- R6: With `pci_stop_n` low, lanes 3..8 are held low. Lane 2 keeps running.
- R7: Each control pin passes through a two-flop synchronizer. Power-down is qualified only after the synchronized `pwrdn_n` has been low on two consecutive rising edges. A low pulse seen on a single edge has no effect.
- R8: Under qualified power-down every lane, including the free-running ones, is held low, regardless of the enable bits.
- R9: `pwrdn_status` is 1 exactly when power-down is qualified and every gate is closed. While it is 1, `lane_out` is all zero.
- R10: A lane other than 2, 15 and 17 whose `lane_en` bit is 0 is held low and does not switch.
- R11: The `lane_en` bits of lanes 2, 15 and 17 have no effect on those lanes.
- R12: Removing a stop or power-down request lets each affected lane reopen at the next falling edge of its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (processor-domain) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous stop of processor lane 0, active low |
| pci_stop_n | input | 1 | Asynchronous stop of gated PCI lanes 3..8, active low |
| lane_en | input | NUM_LANES | Per-lane enable bits from configuration, 1 = enabled |
| lane_in | input | NUM_LANES | Generated clock lanes, synchronous to `clk` |
| lane_out | output | NUM_LANES | Gated clock lanes |
| pwrdn_status | output | 1 | Qualified power-down in force with all lanes held low |

## Verification
The most delicate overlap is a stop request being released in the same cycle that a power-down is requested. The synchronized stop drops one edge before power-down qualifies. For that one cycle a PCI lane sees no hold, and if its input falls in that cycle it reopens for a full pulse before power-down closes it again. The bench provokes this by driving `pci_stop_n` high and `pwrdn_n` low on the same falling edge of `clk`. It judges the outcome by comparing every lane each cycle against a behavioural model that computes the request pipelines and the reopen/close decisions on its own. A second overlap drives a processor stop together with power-down, so that both requests converge on lane 0.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Fixed lane positions before the PCI and SDRAM groups.
  localparam int CPU_IDX   = 0;
  localparam int CPUF_IDX  = 1;
  localparam int PCIF_IDX  = 2;
  localparam int PCI0_IDX  = 3;
  // Lanes that follow the SDRAM group: hub clock, 66 MHz, reference, USB, dot, video.
  localparam int TAIL_LANES = 6;

  function automatic int lane_total(input int np, input int ns);
    return PCI0_IDX + np + ns + TAIL_LANES;
  endfunction

  function automatic int hub_idx(input int np, input int ns);
    return PCI0_IDX + np + ns;
  endfunction

  function automatic int ref_idx(input int np, input int ns);
    return PCI0_IDX + np + ns + 2;
  endfunction

  // Lanes held by the processor stop request.
  function automatic logic [63:0] cpu_stop_mask();
    logic [63:0] m;
    m = '0;
    m[CPU_IDX] = 1'b1;
    return m;
  endfunction

  // Lanes held by the PCI stop request.
  function automatic logic [63:0] pci_stop_mask(input int np);
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < np; k++) m[PCI0_IDX + k] = 1'b1;
    return m;
  endfunction

  // Lanes whose enable bit is honoured: all except the free-running three.
  function automatic logic [63:0] cfg_mask(input int np, input int ns);
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < lane_total(np, ns); k++) m[k] = 1'b1;
    m[PCIF_IDX]       = 1'b0;
    m[hub_idx(np, ns)] = 1'b0;
    m[ref_idx(np, ns)] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int         W      = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
  parameter int               N        = 21,
  parameter logic [N-1:0]     CPU_M    = '0,
  parameter logic [N-1:0]     PCI_M    = '0,
  parameter logic [N-1:0]     CFG_M    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pd_s_n,
  input  logic         cpu_s_n,
  input  logic         pci_s_n,
  input  logic [N-1:0] lane_en,
  output logic         pd_active,
  output logic [N-1:0] hold
);
  // Previous synchronized power-down sample; qualification needs two lows in a row.
  logic pd_prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_prev_n <= 1'b1;
    else        pd_prev_n <= pd_s_n;
  end

  assign pd_active = ~pd_s_n & ~pd_prev_n;

  logic [N-1:0] cpu_hold, pci_hold, cfg_hold;

  assign cpu_hold = CPU_M & {N{~cpu_s_n}};
  assign pci_hold = PCI_M & {N{~pci_s_n}};
  assign cfg_hold = CFG_M & ~lane_en;

  assign hold = {N{pd_active}} | cpu_hold | pci_hold | cfg_hold;
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic lane_in,
  input  logic hold,
  output logic lane_out,
  output logic gate_open
);
  logic prev_q;
  logic open_q;
  logic out_q;
  logic fall_now;

  // The gate state may change only when the lane input has just gone low.
  assign fall_now = prev_q & ~lane_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      open_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      prev_q <= lane_in;
      out_q  <= lane_in & open_q;
      if (fall_now) open_q <= ~hold;
    end
  end

  assign lane_out  = out_q;
  assign gate_open = open_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int NUM_PCI   = 6,
  parameter int NUM_SDRAM = 6,
  localparam int NUM_LANES = clkgate_pkg::lane_total(NUM_PCI, NUM_SDRAM)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwrdn_n,
  input  logic                 cpu_stop_n,
  input  logic                 pci_stop_n,
  input  logic [NUM_LANES-1:0] lane_en,
  input  logic [NUM_LANES-1:0] lane_in,
  output logic [NUM_LANES-1:0] lane_out,
  output logic                 pwrdn_status
);
  localparam logic [NUM_LANES-1:0] CPU_M =
    NUM_LANES'(clkgate_pkg::cpu_stop_mask());
  localparam logic [NUM_LANES-1:0] PCI_M =
    NUM_LANES'(clkgate_pkg::pci_stop_mask(NUM_PCI));
  localparam logic [NUM_LANES-1:0] CFG_M =
    NUM_LANES'(clkgate_pkg::cfg_mask(NUM_PCI, NUM_SDRAM));

  logic [2:0] req_s_n;
  logic       pd_active;
  logic [NUM_LANES-1:0] hold;
  logic [NUM_LANES-1:0] open_vec;

  clkgate_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({pci_stop_n, cpu_stop_n, pwrdn_n}),
    .sync_out (req_s_n)
  );

  clkgate_ctrl #(
    .N     (NUM_LANES),
    .CPU_M (CPU_M),
    .PCI_M (PCI_M),
    .CFG_M (CFG_M)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_s_n    (req_s_n[0]),
    .cpu_s_n   (req_s_n[1]),
    .pci_s_n   (req_s_n[2]),
    .lane_en   (lane_en),
    .pd_active (pd_active),
    .hold      (hold)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    clkgate_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_in   (lane_in[g]),
      .hold      (hold[g]),
      .lane_out  (lane_out[g]),
      .gate_open (open_vec[g])
    );
  end

  assign pwrdn_status = pd_active & ~|open_vec;
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N = 21
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwrdn_n,
  input logic [N-1:0] lane_in,
  input logic [N-1:0] lane_out,
  input logic         pwrdn_status
);
  for (genvar g = 0; g < N; g++) begin : g_prop
    // R3: an output falls only after its input was already low.
    assert_fall_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lane_out[g]) |-> !$past(lane_in[g]));

    // R4: an output rises only after a full low phase of its input.
    assert_full_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lane_out[g]) |-> ($past(lane_in[g]) && !$past(lane_in[g], 2)));
  end

  // R9: a reported power-down means every output is low.
  assert_quiet_when_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_status |-> (lane_out == '0));

  // R7: a reported power-down requires two consecutive low samples of the pin.
  assert_two_low_samples_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_status |-> (!$past(pwrdn_n, 2) && !$past(pwrdn_n, 3)));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N(NUM_LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwrdn_n      (pwrdn_n),
  .lane_in      (lane_in),
  .lane_out     (lane_out),
  .pwrdn_status (pwrdn_status)
);

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;
  localparam int N = 21;
  localparam logic [N-1:0] FREE_CFG = (N'(1) << 2) | (N'(1) << 15) | (N'(1) << 17);
  localparam logic [N-1:0] PCI_SET  = N'(6'h3F) << 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
  logic [N-1:0] lane_en = '1;
  logic [N-1:0] lane_in = '0;
  logic [N-1:0] lane_out;
  logic pwrdn_status;

  always #5 clk = ~clk;

  clk_stop_gate uut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .lane_en(lane_en), .lane_in(lane_in),
    .lane_out(lane_out), .pwrdn_status(pwrdn_status)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R2";
  int cnt [N];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [N-1:0] m_open, m_prev, m_out;
  logic m_pd_s, m_pd_last, m_cpu_s, m_pci_s;
  logic q_pd[$], q_cpu[$], q_pci[$];

  function automatic bit m_pd_ok();
    return !m_pd_s && !m_pd_last;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = '0; m_prev = '0; m_out = '0;
      m_pd_s = 1; m_pd_last = 1; m_cpu_s = 1; m_pci_s = 1;
      q_pd = '{1'b1}; q_cpu = '{1'b1}; q_pci = '{1'b1};
    end else begin
      for (int i = 0; i < N; i++) begin
        bit h;
        h = m_pd_ok();
        if (i == 0 && !m_cpu_s) h = 1;
        if (i >= 3 && i <= 8 && !m_pci_s) h = 1;
        if (!FREE_CFG[i] && !lane_en[i]) h = 1;
        m_out[i] = lane_in[i] & m_open[i];
        if (m_prev[i] && !lane_in[i]) m_open[i] = !h;
        m_prev[i] = lane_in[i];
      end
      m_pd_last = m_pd_s;
      q_pd.push_back(pwrdn_n);    m_pd_s  = q_pd.pop_front();
      q_cpu.push_back(cpu_stop_n); m_cpu_s = q_cpu.pop_front();
      q_pci.push_back(pci_stop_n); m_pci_s = q_pci.pop_front();
    end
  end

  // Compare, then advance the lane waveforms, on the falling edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(lane_out == m_out, cur_req, 32'(lane_out), 32'(m_out));
      chk(pwrdn_status == (m_pd_ok() && m_open == '0), "R9", 32'(pwrdn_status),
          32'(m_pd_ok() && m_open == '0));
    end
    for (int i = 0; i < N; i++) begin
      cnt[i]++;
      if (cnt[i] >= 1 + (i % 3)) begin
        lane_in[i] <= ~lane_in[i];
        cnt[i] = 0;
      end
    end
  end

  logic [N-1:0] seen_hi;
  task automatic watch(input int n);
    seen_hi = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      seen_hi |= lane_out;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) cnt[i] = i % 2;
    repeat (4) @(negedge clk);
    chk(lane_out == '0, "R1", 32'(lane_out), 0);
    chk(pwrdn_status == 1'b0, "R1", 32'(pwrdn_status), 0);
    rst_n = 1'b1;
    cmp_on = 1;

    cur_req = "R2"; watch(30);
    chk(seen_hi == '1, "R2", 32'(seen_hi), 32'(N'('1)));

    cur_req = "R5"; cpu_stop_n = 1'b0; repeat (10) @(negedge clk);
    watch(12);
    chk(seen_hi[0] == 1'b0, "R5", 32'(seen_hi[0]), 0);
    chk(seen_hi[1] == 1'b1, "R5", 32'(seen_hi[1]), 1);
    cur_req = "R12"; cpu_stop_n = 1'b1; repeat (10) @(negedge clk);
    watch(12);
    chk(seen_hi[0] == 1'b1, "R12", 32'(seen_hi[0]), 1);

    cur_req = "R6"; pci_stop_n = 1'b0; repeat (10) @(negedge clk);
    watch(12);
    chk((seen_hi & PCI_SET) == '0, "R6", 32'(seen_hi & PCI_SET), 0);
    chk(seen_hi[2] == 1'b1, "R6", 32'(seen_hi[2]), 1);
    cur_req = "R4"; pci_stop_n = 1'b1; repeat (20) @(negedge clk);

    cur_req = "R7"; pwrdn_n = 1'b0; @(negedge clk); pwrdn_n = 1'b1;
    repeat (4) @(negedge clk);
    watch(12);
    chk(seen_hi == '1, "R7", 32'(seen_hi), 32'(N'('1)));
    chk(pwrdn_status == 1'b0, "R7", 32'(pwrdn_status), 0);

    cur_req = "R8"; pwrdn_n = 1'b0; repeat (12) @(negedge clk);
    watch(12);
    chk(seen_hi == '0, "R8", 32'(seen_hi), 0);
    chk(pwrdn_status == 1'b1, "R9", 32'(pwrdn_status), 1);
    cur_req = "R12"; pwrdn_n = 1'b1; repeat (20) @(negedge clk);
    chk(pwrdn_status == 1'b0, "R9", 32'(pwrdn_status), 0);

    cur_req = "R10"; lane_en = '0; repeat (10) @(negedge clk);
    watch(12);
    chk((seen_hi & ~FREE_CFG) == '0, "R10", 32'(seen_hi & ~FREE_CFG), 0);
    chk((seen_hi & FREE_CFG) == FREE_CFG, "R11", 32'(seen_hi & FREE_CFG), 32'(FREE_CFG));
    lane_en = '1; repeat (20) @(negedge clk);

    // Collisions: stop released as power-down starts; stop and power-down together.
    cur_req = "R3"; pci_stop_n = 1'b0; repeat (12) @(negedge clk);
    for (int d = 0; d < 6; d++) begin
      pci_stop_n = 1'b1; pwrdn_n = 1'b0; repeat (15) @(negedge clk);
      pwrdn_n = 1'b1; pci_stop_n = 1'b0; repeat (7 + d) @(negedge clk);
    end
    pci_stop_n = 1'b1;
    cur_req = "R5"; cpu_stop_n = 1'b0; pwrdn_n = 1'b0; repeat (15) @(negedge clk);
    cpu_stop_n = 1'b1; repeat (3) @(negedge clk);
    chk(lane_out == '0, "R8", 32'(lane_out), 0);
    pwrdn_n = 1'b1; repeat (20) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule